// File: doc/BRIEF.md
# Default Memory Region Attribute Decoder

This block assigns a memory attribute byte to every physical address the core presents. One 64-bit configuration word holds two 4 KB-granular limits: the top of general-purpose system memory and the base of the boot ROM. It also holds one attribute byte for each of the three regions these limits carve out. Addresses under the top-of-memory limit fall in the system region. Addresses from that limit up to the ROM base fall in the middle region. Addresses from the ROM base upward fall in the ROM region.

Inside the system region, a fixed legacy window from 000A0000h through 000FFFFFh takes its attribute byte from a separate input rather than from the system byte. The decoded byte is registered and returned one cycle after a qualified request. It comes out both as a raw byte and as six separate behaviour flags.

Top module: `mem_region_attr_dec`

## Requirements
- R1: After reset the configuration word is 01FFFFF0_10000001h. This gives a ROM base page of FFFFFh, a top-of-memory page of 0 and 01h in every attribute byte. Before any request, rsp_valid and rsp_attr read 0.
- R2: A write stores cfg_wdata whole. The ROM attribute byte sits in bits 63:56, the ROM base page in 55:36, the middle attribute byte in 35:28, the top-of-memory page in 27:8 and the system attribute byte in 7:0. Without a write the word does not change.
- R3: An address whose page (address bits 31:12) is below the top-of-memory page, and below the ROM base page, returns the system attribute byte. The legacy window is the exception.
- R4: An address whose page is at or above the top-of-memory page and below the ROM base page returns the middle attribute byte.
- R5: An address whose page is at or above the ROM base page returns the ROM attribute byte, including a page exactly equal to the base.
- R6: When the top-of-memory page exceeds the ROM base page, the ROM region still wins for every page at or above the ROM base.
- R7: An address from 000A0000h to 000FFFFFh inclusive that falls in the system region returns legacy_attr as sampled with the request. 0009FFFFh and 00100000h do not. A window address outside the system region uses that region's byte.
- R8: The flag outputs decode the returned byte as follows: bit 0 is cache-disable, bit 1 write-allocate, bit 2 write-protect, bit 3 write-through, bit 4 write-combine and bit 5 write-serialize. Bits 7:6 are reserved. They appear in rsp_attr exactly as stored but drive no flag.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high, with one result per request in order. Back-to-back requests are supported.
- R10: A configuration write in the same cycle as a request does not change that request's result. It applies from the next request on.
- R11: Address bits 11:0 play no part in the region choice, except inside the fixed legacy window test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier |
| req_addr | input | 32 | Physical address to classify |
| legacy_attr | input | 8 | Attribute byte for the legacy window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | New configuration word |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_attr | output | 8 | Selected attribute byte, reserved bits included |
| rsp_cd | output | 1 | Cache-disable flag |
| rsp_wa | output | 1 | Write-allocate flag |
| rsp_wp | output | 1 | Write-protect flag |
| rsp_wt | output | 1 | Write-through flag |
| rsp_wc | output | 1 | Write-combine flag |
| rsp_ws | output | 1 | Write-serialize flag |

## Verification
Every cycle, the assertions check these properties:
- the configuration word moves only on a write and takes exactly the written value;
- each response follows its request by one cycle;
- any page at or above the ROM base returns the ROM byte;
- a page between the two limits returns the middle byte;
- a legacy-window address in the system region returns the legacy byte sampled with the request.

Other behaviour only the scenarios can show. This covers the reset values, the exact edges of the legacy window, and the placement of the reserved bits in the byte versus the flags. It also covers the write-during-request ordering, and the case where the top of memory overlaps the ROM base.

// File: rtl/mra_pkg.sv
package mra_pkg;
   localparam int unsigned CFG_W  = 64;
   localparam int unsigned ATTR_W = 8;
   localparam int unsigned LIM_W  = 20;
   localparam int unsigned FLAG_N = 6;

   localparam int unsigned SYS_ATTR_LSB = 0;
   localparam int unsigned SYS_TOP_LSB  = SYS_ATTR_LSB + ATTR_W;
   localparam int unsigned MID_ATTR_LSB = SYS_TOP_LSB + LIM_W;
   localparam int unsigned ROM_BASE_LSB = MID_ATTR_LSB + ATTR_W;
   localparam int unsigned ROM_ATTR_LSB = ROM_BASE_LSB + LIM_W;

   localparam logic [CFG_W-1:0] CFG_RESET = 64'h01FF_FFF0_1000_0001;

   typedef struct packed {
      logic ws;
      logic wc;
      logic wt;
      logic wp;
      logic wa;
      logic cd;
   } attr_flags_t;
endpackage

// File: rtl/mra_cfg_reg.sv
module mra_cfg_reg
   import mra_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [ATTR_W-1:0] rom_attr,
   output logic [LIM_W-1:0]  rom_base,
   output logic [ATTR_W-1:0] mid_attr,
   output logic [LIM_W-1:0]  sys_top,
   output logic [ATTR_W-1:0] sys_attr
);
   if (ROM_ATTR_LSB + ATTR_W != CFG_W) begin : g_bad_layout
      $error("configuration fields do not fill the word");
   end

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= RESET_VAL;
      else if (we) cfg_q <= wdata;
   end

   assign rom_attr = cfg_q[ROM_ATTR_LSB +: ATTR_W];
   assign rom_base = cfg_q[ROM_BASE_LSB +: LIM_W];
   assign mid_attr = cfg_q[MID_ATTR_LSB +: ATTR_W];
   assign sys_top  = cfg_q[SYS_TOP_LSB  +: LIM_W];
   assign sys_attr = cfg_q[SYS_ATTR_LSB +: ATTR_W];

   // R2: the word holds still unless written
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(we) |-> $stable(cfg_q));
   // R2: a write lands exactly
   p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we) |-> cfg_q == $past(wdata));
endmodule

// File: rtl/mra_region_sel.sv
module mra_region_sel
   import mra_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter bit          LEG_EN     = 1'b1,
   parameter logic [31:0] LEG_FIRST  = 32'h000A_0000,
   parameter logic [31:0] LEG_LAST   = 32'h000F_FFFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LIM_W-1:0]  rom_base,
   input  logic [LIM_W-1:0]  sys_top,
   input  logic [ATTR_W-1:0] rom_attr,
   input  logic [ATTR_W-1:0] mid_attr,
   input  logic [ATTR_W-1:0] sys_attr,
   input  logic [ATTR_W-1:0] leg_attr,
   output logic [ATTR_W-1:0] attr_sel
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

   if (PAGE_W != LIM_W) begin : g_bad_page
      $error("page number width must match the limit fields");
   end

   logic [PAGE_W-1:0] page;
   logic in_rom, in_mid, in_leg;

   assign page   = addr[ADDR_W-1:PAGE_SHIFT];
   assign in_rom = page >= rom_base;
   assign in_mid = page >= sys_top;

   if (LEG_EN) begin : g_leg
      localparam logic [ADDR_W-1:0] LF = ADDR_W'(LEG_FIRST);
      localparam logic [ADDR_W-1:0] LL = ADDR_W'(LEG_LAST);
      assign in_leg = (addr >= LF) && (addr <= LL);
   end else begin : g_no_leg
      assign in_leg = 1'b0;
   end

   always_comb begin
      if (in_rom)      attr_sel = rom_attr;
      else if (in_mid) attr_sel = mid_attr;
      else if (in_leg) attr_sel = leg_attr;
      else             attr_sel = sys_attr;
   end
endmodule

// File: rtl/mra_attr_out.sv
module mra_attr_out
   import mra_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ATTR_W-1:0] attr_sel,
   output logic              rsp_valid,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic [FLAG_N-1:0] rsp_flags
);
   if (FLAG_N > ATTR_W) begin : g_bad_flags
      $error("more flags than attribute bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_attr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_attr <= attr_sel;
      end
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      assign rsp_flags[i] = rsp_attr[i];
   end

   // R9: one response per request, one cycle later
   p_rsp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));
endmodule

// File: rtl/mem_region_attr_dec.sv
module mem_region_attr_dec
   import mra_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter bit          LEG_EN     = 1'b1,
   parameter logic [31:0] LEG_FIRST  = 32'h000A_0000,
   parameter logic [31:0] LEG_LAST   = 32'h000F_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        legacy_attr,
   input  logic              cfg_we,
   input  logic [63:0]       cfg_wdata,
   output logic              rsp_valid,
   output logic [7:0]        rsp_attr,
   output logic              rsp_cd,
   output logic              rsp_wa,
   output logic              rsp_wp,
   output logic              rsp_wt,
   output logic              rsp_wc,
   output logic              rsp_ws
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

   if (LEG_FIRST > LEG_LAST) begin : g_bad_window
      $error("legacy window bounds reversed");
   end

   logic [ATTR_W-1:0] rom_attr, mid_attr, sys_attr, attr_sel;
   logic [LIM_W-1:0]  rom_base, sys_top;
   logic [FLAG_N-1:0] flags;
   attr_flags_t       fl;

   mra_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rom_attr(rom_attr), .rom_base(rom_base), .mid_attr(mid_attr),
      .sys_top(sys_top), .sys_attr(sys_attr)
   );

   mra_region_sel #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LEG_EN(LEG_EN),
      .LEG_FIRST(LEG_FIRST), .LEG_LAST(LEG_LAST)
   ) u_sel (
      .addr(req_addr), .rom_base(rom_base), .sys_top(sys_top),
      .rom_attr(rom_attr), .mid_attr(mid_attr), .sys_attr(sys_attr),
      .leg_attr(legacy_attr), .attr_sel(attr_sel)
   );

   mra_attr_out u_out (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .attr_sel(attr_sel),
      .rsp_valid(rsp_valid), .rsp_attr(rsp_attr), .rsp_flags(flags)
   );

   assign fl     = attr_flags_t'(flags);
   assign rsp_cd = fl.cd;
   assign rsp_wa = fl.wa;
   assign rsp_wp = fl.wp;
   assign rsp_wt = fl.wt;
   assign rsp_wc = fl.wc;
   assign rsp_ws = fl.ws;

   // R5: at or above the ROM base page the ROM byte wins
   p_rom_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && ($past(req_addr[ADDR_W-1:PAGE_SHIFT]) >= $past(rom_base))
      |-> rsp_attr == $past(rom_attr));
   // R4: between the limits the middle byte is used
   p_mid_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && ($past(req_addr[ADDR_W-1:PAGE_SHIFT]) < $past(rom_base))
      && ($past(req_addr[ADDR_W-1:PAGE_SHIFT]) >= $past(sys_top))
      |-> rsp_attr == $past(mid_attr));

   if (LEG_EN) begin : g_leg_chk
      localparam logic [ADDR_W-1:0] LF = ADDR_W'(LEG_FIRST);
      localparam logic [ADDR_W-1:0] LL = ADDR_W'(LEG_LAST);
      logic [PAGE_W-1:0] pg;
      assign pg = req_addr[ADDR_W-1:PAGE_SHIFT];
      // R7: legacy window inside system memory takes the legacy byte
      p_legacy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid && $past(req_addr >= LF && req_addr <= LL)
         && $past(pg < sys_top && pg < rom_base)
         |-> rsp_attr == $past(legacy_attr));
   end
endmodule

// File: tb/mem_region_attr_dec_test.sv
module mem_region_attr_dec_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [7:0]  legacy_attr = '0;
   logic        cfg_we = 1'b0;
   logic [63:0] cfg_wdata = '0;
   logic        rsp_valid, rsp_cd, rsp_wa, rsp_wp, rsp_wt, rsp_wc, rsp_ws;
   logic [7:0]  rsp_attr;

   int checks = 0;
   int errors = 0;
   logic [63:0] shadow = 64'h01FF_FFF0_1000_0001;
   logic [7:0]  exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   mem_region_attr_dec uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .legacy_attr(legacy_attr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .rsp_valid(rsp_valid), .rsp_attr(rsp_attr), .rsp_cd(rsp_cd),
      .rsp_wa(rsp_wa), .rsp_wp(rsp_wp), .rsp_wt(rsp_wt), .rsp_wc(rsp_wc),
      .rsp_ws(rsp_ws)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model(input logic [63:0] c, input logic [31:0] a,
                                        input logic [7:0] l);
      logic [19:0] pg;
      pg = a[31:12];
      if (pg >= c[55:36])                          return c[63:56];
      else if (pg >= c[27:8])                      return c[35:28];
      else if (a >= 32'hA0000 && a <= 32'hFFFFF)   return l;
      else                                         return c[7:0];
   endfunction

   task automatic req(input logic [31:0] a, input logic [7:0] l, input string t);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; legacy_attr = l; cfg_we = 1'b0;
      exp_q.push_back(model(shadow, a, l)); tag_q.push_back(t);
   endtask

   task automatic wr(input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = d; shadow = d;
   endtask

   task automatic req_wr(input logic [31:0] a, input logic [7:0] l,
                         input logic [63:0] d, input string t);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; legacy_attr = l;
      cfg_we = 1'b1; cfg_wdata = d;
      exp_q.push_back(model(shadow, a, l)); tag_q.push_back(t);
      shadow = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; cfg_we = 1'b0;
      end
   endtask

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected response", 64'(rsp_attr), 64'h0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rsp_attr == e, t, 64'(rsp_attr), 64'(e));
            chk({rsp_ws, rsp_wc, rsp_wt, rsp_wp, rsp_wa, rsp_cd} == e[5:0],
                {"R8 flags ", t},
                64'({rsp_ws, rsp_wc, rsp_wt, rsp_wp, rsp_wa, rsp_cd}), 64'(e[5:0]));
         end
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] cfg_a, cfg_b;
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0 && rsp_attr == 8'h00, "R1 reset outputs",
          64'({rsp_valid, rsp_attr}), 64'h0);
      rst_n = 1'b1;
      // R1: reset configuration
      req(32'h0000_0000, 8'hFF, "R1 page0 middle");
      req(32'h000A_0000, 8'hFF, "R1 legacy outside system");
      req(32'hFFFF_EFFF, 8'h00, "R1 below rom");
      req(32'hFFFF_F000, 8'h00, "R1 rom");
      idle(3);
      chk(rsp_valid == 1'b0, "R9 idle", 64'(rsp_valid), 64'h0);

      // R2: program fields; reserved bits in system and ROM bytes (R8)
      cfg_a = {8'h65, 20'hFFF00, 8'h11, 20'h08000, 8'hC2};
      wr(cfg_a);
      idle(1);
      req(32'h0000_1000, 8'h00, "R3 system");
      req(32'h07FF_FFFF, 8'h00, "R3 last system byte");
      req(32'h0800_0000, 8'h00, "R4 top boundary");
      req(32'h0800_0FFF, 8'h00, "R11 page offset ignored");
      req(32'hFFEF_FFFF, 8'h00, "R4 below rom");
      req(32'hFFF0_0000, 8'h00, "R5 rom base equal");
      req(32'hFFFF_FFFF, 8'h00, "R5 rom top");
      req(32'h000A_0000, 8'h3C, "R7 window first");
      req(32'h000F_FFFF, 8'h0A, "R7 window last");
      req(32'h0009_FFFF, 8'h3C, "R7 just below window");
      req(32'h0010_0000, 8'h3C, "R7 just above window");
      req(32'h07FF_F001, 8'h00, "R11 offset in system");
      idle(2);

      // R10: write in the same cycle as a request
      cfg_b = {cfg_a[63:8], 8'h08};
      req_wr(32'h0000_1000, 8'h00, cfg_b, "R10 old value");
      req(32'h0000_1000, 8'h00, "R10 new value");
      idle(2);

      // R6: top of memory above ROM base
      wr({8'h2A, 20'h80000, 8'h14, 20'hF0000, 8'h03});
      req(32'h9000_0000, 8'h00, "R6 rom over top");
      req(32'h8000_0000, 8'h00, "R6 rom base equal");
      req(32'h7FFF_F000, 8'h00, "R6 system below rom");
      req(32'h000B_8000, 8'h21, "R7 window in system");
      idle(2);

      // R7: top of memory zero puts window in middle region
      wr({8'h01, 20'hFFFFF, 8'h18, 20'h00000, 8'h04});
      req(32'h000C_0000, 8'h3F, "R7 window not system");
      // R5: ROM base zero covers everything
      wr({8'hE0, 20'h00000, 8'h18, 20'h10000, 8'h04});
      req(32'h0000_0000, 8'h00, "R5 rom base zero");
      req(32'h000A_0000, 8'h22, "R5 rom over window");
      idle(3);

      chk(exp_q.size() == 0, "R9 all responses returned", 64'(exp_q.size()), 64'h0);
      chk(rsp_valid == 1'b0, "R9 idle end", 64'(rsp_valid), 64'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule